// File: doc/BRIEF.md
# Byte-Wide I/O Register File with Masked Writes and Colour Palettes

This block holds the control and status bytes in the 128-byte I/O window at the top of a small processor's address map. A bus master writes one byte per cycle into an addressed slot. Each slot applies its own write mask, keeps the bits it must preserve, and may trigger a side effect. These include clearing on write, a one-cycle notification pulse, clearing a flag when read, and an auto-incrementing pointer into a palette memory. Read data is a combinational function of the offset and the current register contents.

A set of extended registers exists only when the colour-mode input is high. They are the bank selectors, the speed-switch byte, the block-transfer address and command bytes, and the two palette pointer/data pairs. When colour mode is low, writes to these registers are dropped and reads from them return 0xFF. Each of the two palettes (background and object) has 64 bytes of internal storage. Timers, display timing and DMA engines sit outside this block. It only hands them single-cycle strobes.

Top module: `io_regfile`

## Requirements
- R1: After reset, every implemented register reads 0x00, the video-bank register (offset 0x4F) reads 0xFE, and all strobe outputs are low.
- R2: Plain registers store the full written byte. Their offsets are 0x00, 0x01, 0x02, 0x05, 0x06, 0x07, 0x40, 0x42, 0x43, 0x45, 0x47, 0x48, 0x49, 0x4A, 0x4B, 0x51 and 0x55.
- R3: The interrupt-flag register (offset 0x0F) stores only the written value AND 0x1F.
- R4: A write of any value to the divider register (offset 0x04) leaves it reading 0x00.
- R5: A status write (offset 0x41) keeps the current bits 2:0 and takes bits 6:3 from the data (mask 0x78). `stat_upd_o` is high for exactly the cycle after a write to offset 0x41 or 0x45.
- R6: The video-bank register (0x4F) stores value OR 0xFE. The work-RAM bank register (0x70) stores value AND 0x07. An accepted write to either one raises `map_chg_o` for the following cycle.
- R7: A palette pointer write (background 0x68, object 0x6A) stores value AND 0xBF. It also reloads the paired data register (0x69 / 0x6B) with that palette's entry at pointer bits 5:0.
- R8: A palette data write stores the byte at entry pointer[5:0], and the data register then reads that byte. If pointer bit 7 is set, bits 5:0 then increment, wrapping from 63 to 0, while bit 7 stays set.
- R9: The background and object palettes are separate memories. A write into one never changes the other.
- R10: A read of the serial control register (offset 0x02, with `rd_en` high) returns the stored value in that cycle, and bit 7 is cleared at the next clock edge.
- R11: The speed register (0x4D) takes bit 0 from the data and keeps its own bit 7. The source-low byte (0x52) and the destination-low byte (0x54) store value AND 0xF0. The destination-high byte (0x53) stores value AND 0x1F. A write to 0x55 pulses `hdma_go_o` for the next cycle.
- R12: With `color_en` low, writes to 0x4D, 0x4F, 0x51–0x55, 0x68–0x6B and 0x70 change nothing and raise no strobe, and reads of those offsets return 0xFF.
- R13: Unimplemented offsets and the transfer-trigger offset 0x46 read 0xFF. A write to 0x46 pulses `dma_go_o` for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| color_en | input | 1 | Enables the extended registers |
| wr_en | input | 1 | Write request for the addressed register |
| rd_en | input | 1 | Read request (used for read side effects) |
| addr | input | 7 | Register offset within the I/O window |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Combinational read byte |
| stat_upd_o | output | 1 | Status-relevant register written |
| map_chg_o | output | 1 | A bank selector was written |
| dma_go_o | output | 1 | Object transfer trigger written |
| hdma_go_o | output | 1 | Block transfer command written |

## Verification
The bench builds the block with its default palette depth of 64 entries. It sweeps every one of the 128 offsets with several byte patterns, both with colour mode on and with colour mode off. The 6-bit pointer makes the 63-to-0 wrap reachable within three data writes. The full sweep exposes every per-offset mask, every strobe decode and every gated slot. Re-reading after the colour-off pass shows that dropped writes left the earlier contents in place.

// File: rtl/iorf_pkg.sv
package iorf_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 8;
  typedef logic [ADDR_W-1:0] ofs_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam ofs_t OFS_JOY   = 7'h00;
  localparam ofs_t OFS_SDAT  = 7'h01;
  localparam ofs_t OFS_SCTL  = 7'h02;
  localparam ofs_t OFS_DIV   = 7'h04;
  localparam ofs_t OFS_TCNT  = 7'h05;
  localparam ofs_t OFS_TMOD  = 7'h06;
  localparam ofs_t OFS_TCTL  = 7'h07;
  localparam ofs_t OFS_IRQF  = 7'h0F;
  localparam ofs_t OFS_DCTL  = 7'h40;
  localparam ofs_t OFS_STAT  = 7'h41;
  localparam ofs_t OFS_SCRY  = 7'h42;
  localparam ofs_t OFS_SCRX  = 7'h43;
  localparam ofs_t OFS_LCMP  = 7'h45;
  localparam ofs_t OFS_XFER  = 7'h46;
  localparam ofs_t OFS_PALB  = 7'h47;
  localparam ofs_t OFS_PAL0  = 7'h48;
  localparam ofs_t OFS_PAL1  = 7'h49;
  localparam ofs_t OFS_WINY  = 7'h4A;
  localparam ofs_t OFS_WINX  = 7'h4B;
  localparam ofs_t OFS_SPD   = 7'h4D;
  localparam ofs_t OFS_VBANK = 7'h4F;
  localparam ofs_t OFS_BSRCH = 7'h51;
  localparam ofs_t OFS_BSRCL = 7'h52;
  localparam ofs_t OFS_BDSTH = 7'h53;
  localparam ofs_t OFS_BDSTL = 7'h54;
  localparam ofs_t OFS_BCMD  = 7'h55;
  localparam ofs_t OFS_BGPTR = 7'h68;
  localparam ofs_t OFS_BGDAT = 7'h69;
  localparam ofs_t OFS_OBPTR = 7'h6A;
  localparam ofs_t OFS_OBDAT = 7'h6B;
  localparam ofs_t OFS_WBANK = 7'h70;

  function automatic logic colour_only(input ofs_t a);
    return (a == OFS_SPD) || (a == OFS_VBANK) || (a == OFS_WBANK) ||
           (a >= OFS_BSRCH && a <= OFS_BCMD) ||
           (a >= OFS_BGPTR && a <= OFS_OBDAT);
  endfunction
endpackage

// File: rtl/iorf_pal_ram.sv
module iorf_pal_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/iorf_pal_pair.sv
module iorf_pal_pair #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PAD = 7 - AW
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ptr_we,
  input  logic       dat_we,
  input  logic [7:0] wdata,
  output logic [7:0] ptr_o,
  output logic [7:0] dat_o
);
  logic          auto_q;
  logic [AW-1:0] ptr_q;
  logic [7:0]    dat_q;
  logic [7:0]    ram_rd;

  iorf_pal_ram #(.DEPTH(DEPTH), .WIDTH(8)) u_ram (
    .clk   (clk),
    .we    (dat_we),
    .waddr (ptr_q),
    .wdata (wdata),
    .raddr (wdata[AW-1:0]),
    .rdata (ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_q <= 1'b0;
      ptr_q  <= '0;
      dat_q  <= '0;
    end else if (ptr_we) begin
      auto_q <= wdata[7];
      ptr_q  <= wdata[AW-1:0];
      dat_q  <= ram_rd;
    end else if (dat_we) begin
      dat_q <= wdata;
      if (auto_q) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o = {auto_q, {PAD{1'b0}}, ptr_q};
  assign dat_o = dat_q;

  // R8
  autoinc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_we && !ptr_we && auto_q) |=> (auto_q && ptr_q == $past(ptr_q) + 1'b1));
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_we && !ptr_we && !auto_q) |=> $stable(ptr_q));
endmodule

// File: rtl/io_regfile.sv
module io_regfile
  import iorf_pkg::*;
#(
  parameter int unsigned PAL_ENTRIES = 64,
  localparam int unsigned NPAL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              color_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              stat_upd_o,
  output logic              map_chg_o,
  output logic              dma_go_o,
  output logic              hdma_go_o
);
  byte_t joy_q, sdat_q, sctl_q, div_q, tcnt_q, tmod_q, tctl_q, irqf_q;
  byte_t dctl_q, stat_q, scry_q, scrx_q, lcmp_q, palb_q, pal0_q, pal1_q;
  byte_t winy_q, winx_q, spd_q, vbank_q, wbank_q;
  byte_t bsrch_q, bsrcl_q, bdsth_q, bdstl_q, bcmd_q;
  byte_t pal_ptr [NPAL];
  byte_t pal_dat [NPAL];

  logic wr_ok;
  assign wr_ok = wr_en && (color_en || !colour_only(addr));

  for (genvar g = 0; g < NPAL; g++) begin : g_pal
    localparam ofs_t PTR_OFS = (g == 0) ? OFS_BGPTR : OFS_OBPTR;
    localparam ofs_t DAT_OFS = (g == 0) ? OFS_BGDAT : OFS_OBDAT;
    iorf_pal_pair #(.DEPTH(PAL_ENTRIES)) u_pair (
      .clk    (clk),
      .rst    (rst),
      .ptr_we (wr_ok && addr == PTR_OFS),
      .dat_we (wr_ok && addr == DAT_OFS),
      .wdata  (wr_data),
      .ptr_o  (pal_ptr[g]),
      .dat_o  (pal_dat[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      joy_q <= '0; sdat_q <= '0; sctl_q <= '0; div_q <= '0;
      tcnt_q <= '0; tmod_q <= '0; tctl_q <= '0; irqf_q <= '0;
      dctl_q <= '0; stat_q <= '0; scry_q <= '0; scrx_q <= '0;
      lcmp_q <= '0; palb_q <= '0; pal0_q <= '0; pal1_q <= '0;
      winy_q <= '0; winx_q <= '0; spd_q <= '0; vbank_q <= 8'hFE;
      wbank_q <= '0; bsrch_q <= '0; bsrcl_q <= '0; bdsth_q <= '0;
      bdstl_q <= '0; bcmd_q <= '0;
    end else begin
      if (rd_en && !wr_ok && addr == OFS_SCTL) sctl_q[7] <= 1'b0;
      if (wr_ok) begin
        case (addr)
          OFS_JOY:   joy_q   <= wr_data;
          OFS_SDAT:  sdat_q  <= wr_data;
          OFS_SCTL:  sctl_q  <= wr_data;
          OFS_DIV:   div_q   <= '0;
          OFS_TCNT:  tcnt_q  <= wr_data;
          OFS_TMOD:  tmod_q  <= wr_data;
          OFS_TCTL:  tctl_q  <= wr_data;
          OFS_IRQF:  irqf_q  <= wr_data & 8'h1F;
          OFS_DCTL:  dctl_q  <= wr_data;
          OFS_STAT:  stat_q  <= (stat_q & 8'h07) | (wr_data & 8'h78);
          OFS_SCRY:  scry_q  <= wr_data;
          OFS_SCRX:  scrx_q  <= wr_data;
          OFS_LCMP:  lcmp_q  <= wr_data;
          OFS_PALB:  palb_q  <= wr_data;
          OFS_PAL0:  pal0_q  <= wr_data;
          OFS_PAL1:  pal1_q  <= wr_data;
          OFS_WINY:  winy_q  <= wr_data;
          OFS_WINX:  winx_q  <= wr_data;
          OFS_SPD:   spd_q   <= (spd_q & 8'h80) | (wr_data & 8'h01);
          OFS_VBANK: vbank_q <= wr_data | 8'hFE;
          OFS_WBANK: wbank_q <= wr_data & 8'h07;
          OFS_BSRCH: bsrch_q <= wr_data;
          OFS_BSRCL: bsrcl_q <= wr_data & 8'hF0;
          OFS_BDSTH: bdsth_q <= wr_data & 8'h1F;
          OFS_BDSTL: bdstl_q <= wr_data & 8'hF0;
          OFS_BCMD:  bcmd_q  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_upd_o <= 1'b0;
      map_chg_o  <= 1'b0;
      dma_go_o   <= 1'b0;
      hdma_go_o  <= 1'b0;
    end else begin
      stat_upd_o <= wr_ok && (addr == OFS_STAT || addr == OFS_LCMP);
      map_chg_o  <= wr_ok && (addr == OFS_VBANK || addr == OFS_WBANK);
      dma_go_o   <= wr_ok && addr == OFS_XFER;
      hdma_go_o  <= wr_ok && addr == OFS_BCMD;
    end
  end

  byte_t ext_rd;
  always_comb begin
    case (addr)
      OFS_SPD:   ext_rd = spd_q;
      OFS_VBANK: ext_rd = vbank_q;
      OFS_WBANK: ext_rd = wbank_q;
      OFS_BSRCH: ext_rd = bsrch_q;
      OFS_BSRCL: ext_rd = bsrcl_q;
      OFS_BDSTH: ext_rd = bdsth_q;
      OFS_BDSTL: ext_rd = bdstl_q;
      OFS_BCMD:  ext_rd = bcmd_q;
      OFS_BGPTR: ext_rd = pal_ptr[0];
      OFS_BGDAT: ext_rd = pal_dat[0];
      OFS_OBPTR: ext_rd = pal_ptr[1];
      OFS_OBDAT: ext_rd = pal_dat[1];
      default:   ext_rd = 8'hFF;
    endcase
  end

  always_comb begin
    case (addr)
      OFS_JOY:  rd_data = joy_q;
      OFS_SDAT: rd_data = sdat_q;
      OFS_SCTL: rd_data = sctl_q;
      OFS_DIV:  rd_data = div_q;
      OFS_TCNT: rd_data = tcnt_q;
      OFS_TMOD: rd_data = tmod_q;
      OFS_TCTL: rd_data = tctl_q;
      OFS_IRQF: rd_data = irqf_q;
      OFS_DCTL: rd_data = dctl_q;
      OFS_STAT: rd_data = stat_q;
      OFS_SCRY: rd_data = scry_q;
      OFS_SCRX: rd_data = scrx_q;
      OFS_LCMP: rd_data = lcmp_q;
      OFS_PALB: rd_data = palb_q;
      OFS_PAL0: rd_data = pal0_q;
      OFS_PAL1: rd_data = pal1_q;
      OFS_WINY: rd_data = winy_q;
      OFS_WINX: rd_data = winx_q;
      default:  rd_data = color_en ? ext_rd : 8'hFF;
    endcase
  end

  // R4
  div_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_DIV) |=> (div_q == 8'h00));
  // R5
  stat_low_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_STAT) |=> (stat_q[2:0] == $past(stat_q[2:0])));
  // R5
  stat_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == OFS_STAT || addr == OFS_LCMP)) |=> stat_upd_o);
  // R6
  map_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && color_en && (addr == OFS_VBANK || addr == OFS_WBANK)) |=> map_chg_o);
  // R10
  sctl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == OFS_SCTL) |=> !sctl_q[7]);
  // R12
  gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !color_en && addr == OFS_VBANK) |=> ($stable(vbank_q) && !map_chg_o));
  // R13
  xfer_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_XFER) |=> dma_go_o);
endmodule

// File: tb/tb_io_regfile.sv
`timescale 1ns/1ps
module tb_io_regfile;
  logic clk = 1'b0;
  logic rst, color_en, wr_en, rd_en;
  logic [6:0] addr;
  logic [7:0] wr_data, rd_data;
  logic stat_upd_o, map_chg_o, dma_go_o, hdma_go_o;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] last [128];

  always #5 clk = ~clk;

  io_regfile dut (.clk(clk), .rst(rst), .color_en(color_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .stat_upd_o(stat_upd_o), .map_chg_o(map_chg_o), .dma_go_o(dma_go_o),
    .hdma_go_o(hdma_go_o));

  function automatic bit gated(input int a);
    return a == 'h4D || a == 'h4F || a == 'h70 || (a >= 'h51 && a <= 'h55) ||
           (a >= 'h68 && a <= 'h6B);
  endfunction

  // Value read back after writing v (R2, R3, R4, R5, R6, R7, R11, R13)
  function automatic logic [7:0] stored(input int a, input logic [7:0] v);
    case (a)
      'h00, 'h01, 'h02, 'h05, 'h06, 'h07, 'h40, 'h42, 'h43, 'h45,
      'h47, 'h48, 'h49, 'h4A, 'h4B, 'h51, 'h55, 'h69, 'h6B: return v;
      'h0F, 'h53: return v & 8'h1F;
      'h04: return 8'h00;
      'h41: return v & 8'h78;
      'h4F: return v | 8'hFE;
      'h70: return v & 8'h07;
      'h4D: return v & 8'h01;
      'h52, 'h54: return v & 8'hF0;
      'h68, 'h6A: return v & 8'hBF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    @(negedge clk);
    addr = a[6:0]; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a[6:0];
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic sweep(input bit col, input int pass);
    color_en = col;
    for (int a = 0; a < 128; a++) begin
      logic [7:0] v, e;
      bit acc;
      v = 8'((a * 37 + pass * 91 + 5) & 'hFF);
      acc = col || !gated(a);
      wr(a, v);
      e = (!col && gated(a)) ? 8'hFF : stored(a, v);
      chk(col ? "R2/R3/R4/R6/R11/R13 sweep" : "R12 gated read", rd_data, e);
      chk("R5 stat strobe", {7'd0, stat_upd_o}, {7'd0, (a == 'h41 || a == 'h45)});
      chk("R6 map strobe", {7'd0, map_chg_o}, {7'd0, acc && (a == 'h4F || a == 'h70)});
      chk("R13 dma strobe", {7'd0, dma_go_o}, {7'd0, a == 'h46});
      chk("R11 hdma strobe", {7'd0, hdma_go_o}, {7'd0, acc && a == 'h55});
      if (acc) last[a] = stored(a, v);
      if (col && (a == 'h69 || a == 'h6B) && last[a-1][7])
        last[a-1] = 8'h80 | ((last[a-1] + 8'd1) & 8'h3F);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; color_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 128; a++) rd(a, stored(a, 8'h00), "R1 reset value");
    chk("R1 strobes", {4'd0, stat_upd_o, map_chg_o, dma_go_o, hdma_go_o}, 8'h00);

    sweep(1'b1, 0);
    sweep(1'b0, 1);
    color_en = 1'b1;
    for (int a = 0; a < 128; a++) rd(a, last[a], "R12 ignored write kept contents");
    sweep(1'b1, 2);

    // R5 strobe lasts one cycle
    wr('h45, 8'h12);
    chk("R5 strobe high", {7'd0, stat_upd_o}, 8'h01);
    @(negedge clk); #1;
    chk("R5 strobe one cycle", {7'd0, stat_upd_o}, 8'h00);

    // R10 serial read clears bit 7
    wr('h02, 8'h81);
    chk("R10 stored", rd_data, 8'h81);
    @(negedge clk); addr = 7'h02; rd_en = 1'b1; #1;
    chk("R10 value during read", rd_data, 8'h81);
    @(negedge clk); rd_en = 1'b0; #1;
    chk("R10 bit7 cleared", rd_data, 8'h01);

    // R7/R8 pointer masking, auto-increment and wrap
    wr('h68, 8'hFE);
    chk("R7 pointer mask", rd_data, 8'hBE);
    wr('h69, 8'h11);
    chk("R8 data reg", rd_data, 8'h11);
    rd('h68, 8'hBF, "R8 increment");
    wr('h69, 8'h22);
    rd('h68, 8'h80, "R8 wrap keeps bit7");
    wr('h69, 8'h33);
    rd('h68, 8'h81, "R8 after wrap");
    wr('h68, 8'h3E); rd('h69, 8'h11, "R7 reload entry 62");
    wr('h68, 8'h3F); rd('h69, 8'h22, "R7 reload entry 63");
    wr('h68, 8'h00); rd('h69, 8'h33, "R7 reload entry 0");
    wr('h69, 8'h44);
    rd('h68, 8'h00, "R8 no increment without bit7");
    // R9 independent palettes
    wr('h6A, 8'h3E); wr('h6B, 8'h99);
    wr('h6A, 8'h3E); rd('h6B, 8'h99, "R9 object entry");
    wr('h68, 8'h3E); rd('h69, 8'h11, "R9 background untouched");
    wr('h68, 8'h00); rd('h69, 8'h44, "R8 non-incrementing write stored");

    // R11 speed bit 7 preserved (zero), bit 0 taken
    wr('h4D, 8'hFF); chk("R11 speed", rd_data, 8'h01);
    // R5 status keeps low bits
    wr('h41, 8'hFF); chk("R5 status merge", rd_data, 8'h78);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule